// File: doc/BRIEF.md
# Programmable Time-Base Divider Chain

This block turns a single time-base tick stream into two derived signals. The time base is the block clock qualified by `tb_tick`: each clock cycle with `tb_tick` high counts as one period of the declared time-base frequency. A 22-stage binary chain counts those ticks. The point at which ticks enter the chain depends on the declared frequency: 4.194304 MHz, 1.048576 MHz or 32.768 kHz. Because of this, the last stage always runs at 1 Hz whichever frequency is declared.

A 4-bit rate code routes one of fifteen chain stages to a registered square-wave output. An enable bit gates that output. When re-enabled, the output waits for a clean tap transition so that it never emits a truncated half-cycle.

A separate clock-output strobe runs beside the chain. It marks every time-base period, or every fourth one, as chosen by a divide-select pin. One code of the frequency field holds the whole chain at zero until a valid frequency is declared again.

Top module: `timebase_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, the chain, the clock-output prescaler and the square-wave gate are cleared, so `ck_tick` and `sqw_out` read 0 after that edge.
- R2: With `ck_full` high, `ck_tick` is high in exactly the cycle after each cycle in which `tb_tick` is high, and low otherwise.
- R3: With `ck_full` low, `ck_tick` pulses for one cycle after every fourth `tb_tick`, counted from reset (after the 4th, 8th, ... tick), giving one quarter of the time-base rate.
- R4: `base_sel` encodes the declared frequency: 2'b00 = 4.194304 MHz (ticks enter at stage 0), 2'b01 = 1.048576 MHz (enter at stage 2), 2'b10 = 32.768 kHz (enter at stage 7). Stage k toggles every 2^(k-entry) ticks, so stage 21 runs at 1 Hz for every valid code.
- R5: For `rate_sel` n from 3 to 15, the square wave follows stage n+5, a half-period of 2^(n+5-entry) ticks.
- R6: `rate_sel` 1 and 2 select stages 6 and 7, except with `base_sel` = 2'b10, where they select stages 13 and 14.
- R7: `rate_sel` = 0 routes no tap: `sqw_out` stays low.
- R8: When `sqw_en` is low, `sqw_out` is 0 from the next cycle on. After `sqw_en` rises, `sqw_out` stays low until the selected tap next changes, and then follows the tap with one cycle of delay.
- R9: `base_sel` = 2'b11 holds every chain stage at zero. On return to a valid code, counting restarts from zero, so stage 8 first rises on the 256th tick and `sqw_out` rises one cycle later. `ck_tick` is not affected by this code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_tick | input | 1 | Time-base enable, one pulse per time-base period |
| base_sel | input | 2 | Declared time-base frequency, or chain hold code |
| rate_sel | input | 4 | Square-wave tap code |
| sqw_en | input | 1 | Square-wave output enable |
| ck_full | input | 1 | Clock-output divide select: 1 = full rate, 0 = quarter rate |
| ck_tick | output | 1 | Clock-output strobe, one cycle wide |
| sqw_out | output | 1 | Gated square-wave output |

## Verification
A wrong chain count or a wrong entry stage shows up as a square-wave half-period that is off by a power of two. It can be seen within one half-period of the selected tap, which is at most 8192 cycles in the cases tested. A miswired tap code looks the same way. An error in the hold code or in the re-enable gate shifts the first rising edge of `sqw_out` away from the exact cycle counted from release: cycle 257, or cycle 769 when the enable is re-applied in mid-phase. A prescaler phase error moves a `ck_tick` pulse off the fourth tick within four ticks of reset.

// File: rtl/tbdiv_pkg.sv
// Shared encodings and helper functions for the time-base divider chain.
// Assumes a 2-bit frequency field and stage offsets chosen so that the
// final chain stage always yields 1 Hz.
package tbdiv_pkg;

    typedef enum logic [1:0] {
        BASE_HI   = 2'b00,   // 4.194304 MHz, enters at stage 0
        BASE_MID  = 2'b01,   // 1.048576 MHz, enters at stage 2
        BASE_LOW  = 2'b10,   // 32.768 kHz, enters at stage 7
        BASE_HALT = 2'b11    // chain held at zero
    } base_e;

    localparam int ENTRY_HI  = 0;
    localparam int ENTRY_MID = 2;
    localparam int ENTRY_LOW = 7;

    // Entry stage for a declared frequency (halt code returns 0, unused).
    function automatic int entry_of(base_e b);
        case (b)
            BASE_MID: return ENTRY_MID;
            BASE_LOW: return ENTRY_LOW;
            default:  return ENTRY_HI;
        endcase
    endfunction

endpackage

// File: rtl/tbd_prescale.sv
// Clock-output prescaler: emits a one-cycle strobe per time-base tick,
// or per fourth tick when full rate is not selected. Counts ticks from
// reset; independent of the divider chain and its hold code.
module tbd_prescale #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tb_tick,
    input  logic ck_full,
    output logic ck_tick
);
    localparam logic [DIV_LOG2-1:0] LAST = '1;

    logic [DIV_LOG2-1:0] pre_q;

    // Count time-base ticks modulo 2^DIV_LOG2 and register the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            ck_tick <= 1'b0;
        end else begin
            if (tb_tick) pre_q <= pre_q + 1'b1;
            ck_tick <= tb_tick & (ck_full | (pre_q == LAST));
        end
    end

    // R2: no strobe without a tick in the cycle before.
    assert_no_tick_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_tick |=> !ck_tick);

    // R3: in quarter-rate mode two strobes never follow back to back.
    assert_quarter_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ck_full && ck_tick && !$past(ck_full)) |=> !ck_tick);

endmodule

// File: rtl/tbd_chain.sv
// Binary divider chain of STAGES stages fed by time-base ticks. The tick
// enters at a stage set by the declared frequency, so lower stages stay
// zero. Presents one tap per rate code (code 0 is a constant zero).
module tbd_chain
    import tbdiv_pkg::*;
#(
    parameter int STAGES  = 22,
    parameter int NCODE   = 16,
    parameter int TAP_OFS = 5,
    parameter int ALT_OFS = 12,
    parameter int ALT_MAX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_tick,
    input  base_e            base,
    output logic [NCODE-1:0] taps
);
    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] step;

    // Increment weight: one tick lands on the entry stage.
    always_comb step = STAGES'(1) << entry_of(base);

    // Advance the chain on each tick; hold at zero under reset or halt.
    always_ff @(posedge clk) begin
        if (!rst_n || base == BASE_HALT) cnt_q <= '0;
        else if (tb_tick)                cnt_q <= cnt_q + step;
    end

    assign taps[0] = 1'b0;

    // Route chain stages to rate codes; low codes move for the slow base.
    for (genvar g = 1; g < NCODE; g++) begin : g_tap
        if (g <= ALT_MAX) begin : g_alt
            assign taps[g] = (base == BASE_LOW) ? cnt_q[g + ALT_OFS]
                                                : cnt_q[g + TAP_OFS];
        end else begin : g_std
            assign taps[g] = cnt_q[g + TAP_OFS];
        end
    end

    // R9: under the halt code the chain reads zero one edge later.
    assert_halt_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (base == BASE_HALT) |=> (cnt_q == '0));

    // R4: with no tick and a steady valid base the chain holds its value.
    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tb_tick && base != BASE_HALT) |=> $stable(cnt_q));

endmodule

// File: rtl/tbd_sqwgate.sv
// Square-wave gate: picks the tap for the rate code and registers it to
// the output. After enable rises the output stays low until the tap next
// changes, so no shortened half-cycle is emitted.
module tbd_sqwgate #(
    parameter int NCODE  = 16,
    parameter int RATE_W = $clog2(NCODE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCODE-1:0]  taps,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sqw_en,
    output logic              sqw_out
);
    logic tap;
    logic tap_q;
    logic armed_q;

    // Select the tap for the current rate code (code 0 is tied low).
    always_comb tap = taps[rate_sel];

    // Track tap history, arm on the first transition, and drive the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q   <= 1'b0;
            armed_q <= 1'b0;
            sqw_out <= 1'b0;
        end else begin
            tap_q <= tap;
            if (!sqw_en) begin
                armed_q <= 1'b0;
                sqw_out <= 1'b0;
            end else if (armed_q) begin
                sqw_out <= tap;
            end else if (tap != tap_q) begin
                armed_q <= 1'b1;
                sqw_out <= tap;
            end
        end
    end

    // R8: disabled output reads low from the next cycle.
    assert_off_is_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_en |=> !sqw_out);

    // R7: with no tap routed a low output stays low.
    assert_code0_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0 && !sqw_out) |=> !sqw_out);

endmodule

// File: rtl/timebase_divider.sv
// Top of the time-base divider: clock-output prescaler, divider chain
// and square-wave gate. The time base is clk qualified by tb_tick; the
// frequency field only moves the chain entry point.
module timebase_divider
    import tbdiv_pkg::*;
#(
    parameter int STAGES  = 22,
    parameter int RATE_W  = 4,
    parameter int CK_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tb_tick,
    input  logic [1:0]        base_sel,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              sqw_en,
    input  logic              ck_full,
    output logic              ck_tick,
    output logic              sqw_out
);
    localparam int NCODE = 1 << RATE_W;

    base_e            base;
    logic [NCODE-1:0] taps;

    // Interpret the raw field as the frequency encoding.
    always_comb base = base_e'(base_sel);

    tbd_prescale #(.DIV_LOG2(CK_LOG2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tb_tick (tb_tick),
        .ck_full (ck_full),
        .ck_tick (ck_tick)
    );

    tbd_chain #(.STAGES(STAGES), .NCODE(NCODE)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .tb_tick (tb_tick),
        .base    (base),
        .taps    (taps)
    );

    tbd_sqwgate #(.NCODE(NCODE), .RATE_W(RATE_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .taps     (taps),
        .rate_sel (rate_sel),
        .sqw_en   (sqw_en),
        .sqw_out  (sqw_out)
    );

    // R1: outputs are low in the cycle after a reset edge.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!ck_tick && !sqw_out));

endmodule

// File: tb/sim_timebase_divider.sv
// Self-checking bench: a table of (base, rate, half-period) vectors,
// then directed tests for reset, prescaler, code 0, gating and halt.
module sim_timebase_divider;
    logic       clk = 1'b0;
    logic       rst_n, tb_tick, sqw_en, ck_full;
    logic [1:0] base_sel;
    logic [3:0] rate_sel;
    logic       ck_tick, sqw_out;
    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    timebase_divider u0 (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .base_sel(base_sel),
        .rate_sel(rate_sel), .sqw_en(sqw_en), .ck_full(ck_full),
        .ck_tick(ck_tick), .sqw_out(sqw_out)
    );

    // {base[1:0], rate[3:0], half-period in cycles[15:0]}, tick every cycle
    localparam int NV = 12;
    localparam logic [21:0] VEC [NV] = '{
        {2'b00, 4'd1,  16'd64},    // R6 stage 6
        {2'b00, 4'd2,  16'd128},   // R6 stage 7
        {2'b00, 4'd3,  16'd256},   // R5 stage 8
        {2'b00, 4'd6,  16'd2048},  // R5 stage 11
        {2'b01, 4'd1,  16'd16},    // R4 entry 2, stage 6
        {2'b01, 4'd3,  16'd64},    // R4 entry 2, stage 8
        {2'b01, 4'd9,  16'd4096},  // R4 entry 2, stage 14
        {2'b10, 4'd1,  16'd64},    // R6 slow base, stage 13
        {2'b10, 4'd2,  16'd128},   // R6 slow base, stage 14
        {2'b10, 4'd3,  16'd2},     // R4 entry 7, stage 8
        {2'b10, 4'd10, 16'd256},   // R5 stage 15
        {2'b10, 4'd15, 16'd8192}   // R5 stage 20
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges until sqw_out changes (capped).
    task automatic to_edge(output int n);
        logic prev;
        prev = sqw_out;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sqw_out == prev && n < 20000);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int n;
        int first;
        int hits;
        rst_n = 1'b0; tb_tick = 1'b0; base_sel = 2'b00; rate_sel = 4'd0;
        sqw_en = 1'b0; ck_full = 1'b0;
        repeat (3) @(negedge clk);
        check(!ck_tick, "R1 ck_tick", int'(ck_tick), 0);
        check(!sqw_out, "R1 sqw_out", int'(sqw_out), 0);
        rst_n = 1'b1;

        // R3: quarter rate, strobe after ticks 4 and 8 counted from reset
        for (int i = 1; i <= 8; i++) begin
            tb_tick = 1'b1;
            @(negedge clk);
            check(ck_tick == (i % 4 == 0), "R3 strobe", int'(ck_tick), int'(i % 4 == 0));
            tb_tick = 1'b0;
            @(negedge clk);
            check(!ck_tick, "R3 idle", int'(ck_tick), 0);
        end

        // R2 with the halt code applied (R9: prescaler unaffected)
        ck_full = 1'b1; base_sel = 2'b11;
        for (int i = 1; i <= 6; i++) begin
            tb_tick = 1'b1;
            @(negedge clk);
            check(ck_tick, "R2/R9 strobe", int'(ck_tick), 1);
            tb_tick = 1'b0;
            @(negedge clk);
            check(!ck_tick, "R2 idle", int'(ck_tick), 0);
        end
        ck_full = 1'b0;

        // Vector table: R4, R5, R6 half-periods
        tb_tick = 1'b1; sqw_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            base_sel = VEC[v][21:20];
            rate_sel = VEC[v][19:16];
            to_edge(n);
            to_edge(n);
            to_edge(n);
            check(n == int'(VEC[v][15:0]), "R4/R5/R6 half-period", n, int'(VEC[v][15:0]));
        end

        // R7: code 0 keeps the output low
        base_sel = 2'b00; rate_sel = 4'd0;
        repeat (4) @(negedge clk);
        hits = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (sqw_out) hits++;
        end
        check(hits == 0, "R7 code0 high cycles", hits, 0);

        // R8: disable forces low from the next cycle
        rate_sel = 4'd1;
        repeat (100) @(negedge clk);
        sqw_en = 1'b0;
        @(negedge clk);
        check(!sqw_out, "R8 next cycle", int'(sqw_out), 0);
        hits = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sqw_out) hits++;
        end
        check(hits == 0, "R8 held low", hits, 0);

        // R9: halt holds chain; restart from zero gives rise on cycle 257
        sqw_en = 1'b1; base_sel = 2'b11; rate_sel = 4'd3;
        repeat (20) @(negedge clk);
        check(!sqw_out, "R9 halted low", int'(sqw_out), 0);
        base_sel = 2'b00;
        first = 0;
        for (int i = 1; i <= 400 && first == 0; i++) begin
            @(negedge clk);
            if (sqw_out) first = i;
        end
        check(first == 257, "R9 first rise", first, 257);

        // R8: re-enable mid-phase; waits for fall at 513, rises at 769
        sqw_en = 1'b0; base_sel = 2'b11;
        repeat (20) @(negedge clk);
        base_sel = 2'b00;
        first = 0;
        for (int i = 1; i <= 900 && first == 0; i++) begin
            @(negedge clk);
            if (sqw_out) first = i;
            if (i == 300) sqw_en = 1'b1;
        end
        check(first == 769, "R8 resume rise", first, 769);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule